// File: doc/BRIEF.md
# Posted Write Buffer with Two Burst Tags

This block sits between a processor core and slow external memory. The core hands it store operations, each one word or a run of consecutive words. It then continues with its own work while the block drains those words to memory one at a time. Storage is split into two pools. A data pool holds up to eight words. A tag pool holds up to two run descriptors, each a start address plus a word count. A new store is admitted only when it can get a free tag and enough free words for its whole run.

The core side has two valid/ready streams. On the command stream the core offers a start address and a word count; a command transfers on a clock edge where `wr_cmd_valid` and `wr_cmd_ready` are both high. Once a command is admitted, the data stream opens for exactly that many beats. `wr_dat_ready` stays high for the whole data phase, and no command is taken until the last beat has transferred. While the core offers a command that cannot be admitted, `wr_stall` is high, and the core must hold its offer stable until it transfers. One store therefore costs the core one command cycle plus one cycle per word. On the memory side, `mem_valid` presents one word and its address. Memory takes the word on an edge where `mem_ready` is high. Until then the block holds the address and data unchanged. A core read is granted only when nothing is buffered, so a read can never overtake a pending write.

Top module: `wbuf_post`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) discards all buffered runs and words: afterwards `buf_empty`=1, `buf_full`=0, `mem_valid`=0 and `wr_dat_ready`=0.
- R2: A command with count N (1..8) is admitted (`wr_cmd_ready`=1) only while no data phase is open, a tag is free, and at least N data words are unreserved. Words already buffered and beats still owed by an open data phase both count as reserved. `wr_stall` is 1 exactly when a command is offered and not admitted.
- R3: The data pool never holds more than 8 words.
- R4: No more than 2 runs are held at once. A third command waits until the oldest run has fully drained.
- R5: With room available, a store of N words occupies the core for exactly 1+N cycles. Two single-word stores take 4 cycles, one 8-word store takes 9, and a single-word store followed by a 7-word store takes 10.
- R6: Words leave in strict arrival order. Word k of a run starting at address A goes out with address A+4·k.
- R7: While `mem_valid`=1 and `mem_ready`=0, the next cycle still has `mem_valid`=1 with `mem_addr` and `mem_data` unchanged.
- R8: `rd_go` is 1 only when `rd_req`=1 and the buffer is empty.
- R9: `buf_empty` is 1 when no run is held. `buf_full` is 1 when both tags are in use or all 8 words are reserved.
- R10: `wr_dat_ready` is 1 exactly during a data phase. A data phase opens on the cycle after a command transfers and lasts N beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_cmd_valid | input | 1 | Core offers a store command |
| wr_cmd_ready | output | 1 | Command admitted this cycle |
| wr_cmd_addr | input | 32 | Start byte address of the run |
| wr_cmd_len | input | 4 | Word count, 1 to 8 |
| wr_dat_valid | input | 1 | Core offers a data beat |
| wr_dat_ready | output | 1 | Data phase open |
| wr_dat | input | 32 | Data beat |
| wr_stall | output | 1 | Offered command is being held off |
| rd_req | input | 1 | Core wants to read |
| rd_go | output | 1 | Read may proceed |
| mem_valid | output | 1 | A word is offered to memory |
| mem_ready | input | 1 | Memory accepts the offered word |
| mem_addr | output | 32 | Address of offered word |
| mem_data | output | 32 | Offered word |
| buf_empty | output | 1 | No run buffered |
| buf_full | output | 1 | No tag or no word free |

## Verification
The assertions check the occupancy limits of both pools, the hold rule on the memory handshake, the read gating and the opening of a data phase after each admitted command, all on every cycle. Only the bench scenarios can show the core-side cycle costs of particular store sequences, the order and addresses of drained words, and stalls caused by a missing tag versus missing words. The same goes for recovery once memory drains and for reset discarding a half-filled buffer.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic {ING_IDLE = 1'b0, ING_FILL = 1'b1} ing_state_t;
endpackage

// File: rtl/wbuf_fifo.sv
module wbuf_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        slots[wr_ptr] <= din;
        wr_ptr        <= bump(wr_ptr);
      end
      if (pop) rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign dout  = slots[rd_ptr];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  // R3 / R4: the pool never overflows nor underflows
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    !(push && full && !pop) && (count <= CW'(DEPTH)));
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
    !(pop && empty));
endmodule

// File: rtl/wbuf_ingress.sv
module wbuf_ingress
  import wbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [CW-1:0] cmd_len,
  input  logic          dat_valid,
  input  logic          tag_free,
  input  logic [CW-1:0] free_words,
  output logic          cmd_ready,
  output logic          dat_ready,
  output logic          cmd_fire,
  output logic          dat_fire,
  output logic [CW-1:0] owed
);
  ing_state_t state;

  assign cmd_ready = (state == ING_IDLE) && tag_free &&
                     (cmd_len != '0) && (cmd_len <= CW'(DEPTH)) &&
                     (cmd_len <= free_words);
  assign dat_ready = (state == ING_FILL);
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign dat_fire  = dat_valid && dat_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ING_IDLE;
      owed  <= '0;
    end else begin
      case (state)
        ING_IDLE: if (cmd_fire) begin
          state <= ING_FILL;
          owed  <= cmd_len;
        end
        ING_FILL: if (dat_fire) begin
          owed <= owed - 1'b1;
          if (owed == CW'(1)) state <= ING_IDLE;
        end
        default: state <= ING_IDLE;
      endcase
    end
  end

  // R10: an admitted command opens the data phase on the next cycle
  p_phase_opens_r10: assert property (@(posedge clk) disable iff (rst)
    cmd_fire |=> dat_ready);
  // R10: the final beat closes the phase
  p_phase_closes_r10: assert property (@(posedge clk) disable iff (rst)
    (dat_fire && owed == CW'(1)) |=> !dat_ready);
endmodule

// File: rtl/wbuf_post.sv
module wbuf_post #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int WORDS = 8,
  parameter int TAGS  = 2,
  localparam int CW   = $clog2(WORDS + 1),
  localparam int TCW  = $clog2(TAGS + 1),
  localparam int RW   = AW + CW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_cmd_valid,
  output logic          wr_cmd_ready,
  input  logic [AW-1:0] wr_cmd_addr,
  input  logic [CW-1:0] wr_cmd_len,
  input  logic          wr_dat_valid,
  output logic          wr_dat_ready,
  input  logic [DW-1:0] wr_dat,
  output logic          wr_stall,
  input  logic          rd_req,
  output logic          rd_go,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  output logic          buf_empty,
  output logic          buf_full
);
  logic          cmd_fire, dat_fire, mem_fire;
  logic [CW-1:0] owed, data_cnt, free_words, reserved;
  logic          data_full, data_empty;
  logic [RW-1:0] tag_dout;
  logic [TCW-1:0] tag_cnt;
  logic          tag_full, tag_empty, tag_pop;
  logic [CW-1:0] offset;
  logic [AW-1:0] head_base;
  logic [CW-1:0] head_len;

  assign reserved   = data_cnt + owed;
  assign free_words = CW'(WORDS) - reserved;

  wbuf_ingress #(.DEPTH(WORDS)) u_ing (
    .clk(clk), .rst(rst),
    .cmd_valid(wr_cmd_valid), .cmd_len(wr_cmd_len),
    .dat_valid(wr_dat_valid), .tag_free(!tag_full),
    .free_words(free_words),
    .cmd_ready(wr_cmd_ready), .dat_ready(wr_dat_ready),
    .cmd_fire(cmd_fire), .dat_fire(dat_fire), .owed(owed)
  );

  wbuf_fifo #(.W(DW), .DEPTH(WORDS)) u_data (
    .clk(clk), .rst(rst),
    .push(dat_fire), .din(wr_dat), .pop(mem_fire),
    .dout(mem_data), .count(data_cnt),
    .full(data_full), .empty(data_empty)
  );

  wbuf_fifo #(.W(RW), .DEPTH(TAGS)) u_tags (
    .clk(clk), .rst(rst),
    .push(cmd_fire), .din({wr_cmd_addr, wr_cmd_len}), .pop(tag_pop),
    .dout(tag_dout), .count(tag_cnt),
    .full(tag_full), .empty(tag_empty)
  );

  assign head_base = tag_dout[RW-1 -: AW];
  assign head_len  = tag_dout[CW-1:0];

  assign mem_valid = !data_empty;
  assign mem_fire  = mem_valid && mem_ready;
  assign mem_addr  = head_base + (AW'(offset) << 2);
  assign tag_pop   = mem_fire && (offset == head_len - 1'b1);

  always_ff @(posedge clk) begin
    if (rst)          offset <= '0;
    else if (tag_pop) offset <= '0;
    else if (mem_fire) offset <= offset + 1'b1;
  end

  assign wr_stall  = wr_cmd_valid && !wr_cmd_ready;
  assign buf_empty = tag_empty;
  assign buf_full  = tag_full || data_full || (reserved == CW'(WORDS));
  assign rd_go     = rd_req && tag_empty;

  // R4: tag pool bounded
  p_tag_limit_r4: assert property (@(posedge clk) disable iff (rst)
    tag_cnt <= TCW'(TAGS));
  // R3: reservations never exceed the data pool
  p_reserve_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (data_cnt + owed) <= CW'(WORDS));
  // R7: offered word held until accepted
  p_mem_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));
  // R8: a read never passes a buffered write
  p_read_hold_r8: assert property (@(posedge clk) disable iff (rst)
    rd_go |-> (buf_empty && !mem_valid));
  // R6: words only flow while a run tag is held
  p_word_has_tag_r6: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> !tag_empty);
endmodule

// File: tb/wbuf_post_test.sv
module wbuf_post_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_cmd_valid = 1'b0, wr_dat_valid = 1'b0;
  logic [31:0] wr_cmd_addr = '0, wr_dat = '0;
  logic [3:0]  wr_cmd_len = '0;
  logic        rd_req = 1'b0, mem_ready = 1'b0;
  logic        wr_cmd_ready, wr_dat_ready, wr_stall, rd_go;
  logic        mem_valid, buf_empty, buf_full;
  logic [31:0] mem_addr, mem_data;

  int n_chk = 0, n_bad = 0, wd = 0;
  logic [31:0] exp_a [32];
  logic [31:0] exp_d [32];
  int n_exp = 0;

  always #5 clk = ~clk;

  wbuf_post uut (
    .clk(clk), .rst(rst),
    .wr_cmd_valid(wr_cmd_valid), .wr_cmd_ready(wr_cmd_ready),
    .wr_cmd_addr(wr_cmd_addr), .wr_cmd_len(wr_cmd_len),
    .wr_dat_valid(wr_dat_valid), .wr_dat_ready(wr_dat_ready), .wr_dat(wr_dat),
    .wr_stall(wr_stall), .rd_req(rd_req), .rd_go(rd_go),
    .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data),
    .buf_empty(buf_empty), .buf_full(buf_full)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 50000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 50000", wd);
      summary();
    end
  end

  // issues one store; returns core-side cycles spent
  task automatic store(input logic [31:0] a, input int len, output int cyc);
    logic ok;
    cyc = 0;
    @(negedge clk);
    wr_cmd_valid = 1'b1; wr_cmd_addr = a; wr_cmd_len = 4'(len);
    do begin
      #1 ok = wr_cmd_ready;
      @(posedge clk); cyc++;
      @(negedge clk);
    end while (!ok);
    wr_cmd_valid = 1'b0;
    for (int k = 0; k < len; k++) begin
      wr_dat_valid = 1'b1; wr_dat = a + 32'h5000_0000 + 32'(k);
      exp_a[n_exp] = a + 32'(4 * k); exp_d[n_exp] = wr_dat; n_exp++;
      do begin
        #1 ok = wr_dat_ready;
        @(posedge clk); cyc++;
        @(negedge clk);
      end while (!ok);
    end
    wr_dat_valid = 1'b0;
  endtask

  task automatic drain();
    int idx = 0;
    int guard = 0;
    @(negedge clk);
    mem_ready = 1'b1;
    while (idx < n_exp && guard < 200) begin
      #1;
      if (mem_valid) begin
        check("R6 addr", mem_addr, exp_a[idx]);
        check("R6 data", mem_data, exp_d[idx]);
        idx++;
      end
      @(negedge clk); guard++;
    end
    mem_ready = 1'b0;
    check("R6 count", 32'(idx), 32'(n_exp));
    n_exp = 0;
    #1 check("R9 empty after drain", 32'(buf_empty), 32'd1);
  endtask

  // {addrA, lenA, addrB, lenB(0 = none), expected core cycles}
  localparam logic [79:0] VEC [4] = '{
    {32'h0000_1000, 4'd1, 32'h0000_2000, 4'd1, 8'd4},
    {32'h0000_3000, 4'd8, 32'h0000_0000, 4'd0, 8'd9},
    {32'h0000_4000, 4'd1, 32'h0000_5000, 4'd7, 8'd10},
    {32'h0000_6010, 4'd4, 32'h0000_7020, 4'd4, 8'd10}
  };

  initial begin
    int c1, c2;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1 reset state
    check("R1 empty", 32'(buf_empty), 32'd1);
    check("R1 full", 32'(buf_full), 32'd0);
    check("R1 mem_valid", 32'(mem_valid), 32'd0);
    check("R10 dat_ready idle", 32'(wr_dat_ready), 32'd0);
    rd_req = 1'b1; #1;
    check("R8 read when empty", 32'(rd_go), 32'd1);
    rd_req = 1'b0;

    // R5 / R6 table walk, memory stalled while storing
    for (int v = 0; v < 4; v++) begin
      store(VEC[v][79:48], int'(VEC[v][47:44]), c1);
      c2 = 0;
      if (VEC[v][11:8] != 0) store(VEC[v][43:12], int'(VEC[v][11:8]), c2);
      check("R5 cycles", 32'(c1 + c2), 32'(VEC[v][7:0]));
      #1 check("R9 not empty", 32'(buf_empty), 32'd0);
      drain();
    end

    // R4 tag limit: third run stalls until oldest drains
    store(32'h100, 1, c1);
    store(32'h200, 1, c1);
    @(negedge clk);
    wr_cmd_valid = 1'b1; wr_cmd_addr = 32'h300; wr_cmd_len = 4'd1; #1;
    check("R4 stall third run", 32'(wr_stall), 32'd1);
    check("R9 full two tags", 32'(buf_full), 32'd1);
    repeat (3) @(negedge clk);
    #1 check("R4 still held", 32'(wr_cmd_ready), 32'd0);
    rd_req = 1'b1; #1;
    check("R8 read held", 32'(rd_go), 32'd0);
    rd_req = 1'b0;
    // R7 held while memory not ready
    check("R7 addr held", mem_addr, 32'h100);
    mem_ready = 1'b1;
    @(negedge clk); #1;
    check("R4 admitted after drain", 32'(wr_cmd_ready), 32'd1);
    check("R2 stall clears", 32'(wr_stall), 32'd0);
    wr_cmd_valid = 1'b0; mem_ready = 1'b0;
    exp_a[0] = 32'h200; exp_d[0] = 32'h5000_0200; n_exp = 1;
    drain();

    // R2 word limit: 5 buffered, 4 more do not fit
    store(32'h800, 5, c1);
    @(negedge clk);
    wr_cmd_valid = 1'b1; wr_cmd_addr = 32'h900; wr_cmd_len = 4'd4; #1;
    check("R2 word stall", 32'(wr_stall), 32'd1);
    check("R9 not full", 32'(buf_full), 32'd0);
    wr_cmd_len = 4'd3; #1;
    check("R2 fitting run admitted", 32'(wr_cmd_ready), 32'd1);
    wr_cmd_valid = 1'b0;
    drain();

    // R1 reset discards a partly filled buffer
    store(32'hA00, 3, c1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; #1;
    check("R1 discard empty", 32'(buf_empty), 32'd1);
    check("R1 discard mem_valid", 32'(mem_valid), 32'd0);
    n_exp = 0;
    summary();
  end
endmodule